// File: doc/BRIEF.md
# I2C Slave Address Receiver

This block is the receiving front end of an I2C slave. It works from the system clock. It oversamples SCL and SDA through synchronisers and recognises Start, Repeated Start and Stop. It shifts each byte in on SCL rising edges and decides on the falling edge of the eighth clock whether the byte is accepted. For an accepted byte it either acknowledges it or leaves SDA released. Accepted bytes are copied into a holding buffer, and a flag register records whether that buffer is full or has overflowed. An interrupt flag is raised on the falling edge of the ninth clock.

Either 7-bit or 10-bit addressing is used. A 10-bit address is matched in two passes. After each of the two address bytes, SCL is held low until the host has rewritten the address register.

The host uses a four-entry register port with combinational read data:

| Offset | Contents |
|---|---|
| 0 | Receive buffer. A read strobe clears buffer-full. |
| 1 | Slave address. A write clears the update flag. |
| 2 | Control: bit 0 enable, bit 1 selects 10-bit mode. |
| 3 | Status: bit 0 full, bit 1 overflow, bit 2 interrupt, bit 3 update-address, bit 4 last R/W. Writing 1 to bit 1 or bit 2 clears that flag. |

Top module: `i2cr_rx`

## Requirements
- R1: After reset, every status bit, the control register and the address register read as zero, and scl_pd_o, sda_pd_o and irq_o are low.
- R2: While control bit 0 is clear, or before a Start has been seen, bytes clocked on the bus draw no ACK and change no status bit.
- R3: In 7-bit mode (control bit 1 clear), the first byte after a Start matches when its bits 7:1 equal address register bits 7:1. A matching byte is acknowledged on the ninth clock, is copied into the buffer and sets status bit 0. A non-matching byte draws no ACK and no interrupt, and the bytes after it are ignored until the next Start.
- R4: Every accepted byte sets status bit 2 and irq_o on the ninth falling SCL edge, whether or not it was acknowledged. Writing 1 to status bit 2 clears the flag.
- R5: An accepted byte is transferred and acknowledged only when full and overflow are both clear. Otherwise it is neither transferred nor acknowledged, and the buffer keeps its old value.
- R6: An accepted byte that completes while full is set sets overflow (status bit 1). Overflow stays set until 1 is written to status bit 1.
- R7: Reading offset 0 returns the buffer and clears full.
- R8: In 10-bit mode, a first byte of the form 1111_0,A9,A8,0 whose bits 2:1 equal address register bits 2:1 is accepted. It sets status bit 3, and scl_pd_o then holds SCL low from the ninth falling edge until the host writes offset 1.
- R9: In 10-bit mode, the byte after an accepted high byte must equal the whole address register. If it does, it is accepted, sets status bit 3 and holds SCL. The data bytes that follow are then accepted. If it does not, the byte draws no ACK and no interrupt.
- R10: After a complete 10-bit match, a Repeated Start followed by the high byte with R/W=1 is accepted without setting status bit 3, and it sets status bit 4. After a Stop, the same byte is not accepted.
- R11: A Stop returns the block to idle, and bytes clocked after it without a new Start are ignored.
- R12: When a buffer read strobe falls in the same clock in which a byte is judged, the judgement uses the full flag as it was before the read. The byte is therefore refused and overflow is set, and full is still cleared by the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pd_o | output | 1 | Pull SCL low (clock stretch) |
| sda_pd_o | output | 1 | Pull SDA low (ACK) |
| irq_o | output | 1 | Interrupt flag |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |

## Verification
The host read that empties the buffer and the judgement of a completed byte on the eighth falling edge can land in the same clock. The bench counts the synchroniser and edge-detect registers and raises the read strobe exactly in the clock where the byte is judged. It then checks that the byte was refused with overflow set, that full ended up clear, and that the read returned the old buffer contents. A bus-level reference model tracks the flags byte by byte, and on every clock it checks the stretch output and the interrupt output against that model.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_LO,
    ST_DATA,
    ST_SKIP
  } rx_state_e;

  localparam logic [1:0] RA_RXBUF = 2'd0;
  localparam logic [1:0] RA_SLADR = 2'd1;
  localparam logic [1:0] RA_CTRL  = 2'd2;
  localparam logic [1:0] RA_STAT  = 2'd3;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_TEN = 1;

  localparam int STAT_FULL = 0;
  localparam int STAT_OVF  = 1;
  localparam int STAT_IRQ  = 2;
  localparam int STAT_UPD  = 3;
  localparam int STAT_RW   = 4;

  localparam logic [4:0] TEN_PREFIX = 5'b11110;
endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_in;
  logic [LINES-1:0] line_s;
  logic [LINES-1:0] line_q;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], line_in[g]};
    end
    assign line_s[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '1;
    else        line_q <= line_s;
  end

  assign sda_s     = line_s[1];
  assign scl_rise  = line_s[0] & ~line_q[0];
  assign scl_fall  = ~line_s[0] & line_q[0];
  assign start_det = line_s[0] & line_q[0] & line_q[1] & ~line_s[1];
  assign stop_det  = line_s[0] & line_q[0] & ~line_q[1] & line_s[1];
endmodule

// File: rtl/i2cr_shift.sv
module i2cr_shift
  import i2cr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  output logic [BYTE_W-1:0] sr,
  output logic              byte_end,
  output logic              ack_end
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic              cnt_en, sr_en;

  assign byte_end = scl_fall && (cnt_q == CNT_BYTE);
  assign ack_end  = scl_fall && (cnt_q == CNT_ACK);

  always_comb begin
    cnt_d  = cnt_q;
    sr_d   = sr_q;
    cnt_en = 1'b0;
    sr_en  = 1'b0;
    if (clr || ack_end) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (scl_rise && (cnt_q < CNT_ACK)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
      if (cnt_q < CNT_BYTE) begin
        sr_d  = {sr_q[BYTE_W-2:0], sda_s};
        sr_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (sr_en)  sr_q  <= sr_d;
    end
  end

  assign sr = sr_q;
endmodule

// File: rtl/i2cr_ctrl.sv
module i2cr_ctrl
  import i2cr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              ten_bit,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_end,
  input  logic              ack_end,
  input  logic [BYTE_W-1:0] sr,
  input  logic [BYTE_W-1:0] adr,
  input  logic              buf_full,
  input  logic              ovf,
  output logic              xfer,
  output logic              set_ovf,
  output logic              set_irq,
  output logic              set_upd,
  output logic              rw_we,
  output logic              sda_pd
);
  rx_state_e state_q, state_d;
  logic ten_ok_q, ten_ok_d;
  logic ack_q, ack_d;
  logic irqp_q, irqp_d;
  logic updp_q, updp_d;
  logic act, upd_ev, rw_ev;
  logic seven_ok, hi_ok, lo_ok;

  assign seven_ok = (sr[BYTE_W-1:1] == adr[BYTE_W-1:1]);
  assign hi_ok    = (sr[BYTE_W-1:3] == TEN_PREFIX) && (sr[2:1] == adr[2:1]);
  assign lo_ok    = (sr == adr);

  always_comb begin
    state_d  = state_q;
    ten_ok_d = ten_ok_q;
    ack_d    = ack_q;
    irqp_d   = irqp_q;
    updp_d   = updp_q;
    act      = 1'b0;
    upd_ev   = 1'b0;
    rw_ev    = 1'b0;
    if (!enable || stop_det) begin
      state_d  = ST_IDLE;
      ten_ok_d = 1'b0;
      ack_d    = 1'b0;
      irqp_d   = 1'b0;
      updp_d   = 1'b0;
    end else if (start_det) begin
      if (state_q == ST_IDLE) ten_ok_d = 1'b0;
      state_d = ST_ADDR;
      ack_d   = 1'b0;
      irqp_d  = 1'b0;
      updp_d  = 1'b0;
    end else if (byte_end) begin
      unique case (state_q)
        ST_ADDR: begin
          state_d = ST_SKIP;
          if (!ten_bit) begin
            if (seven_ok) begin
              act     = 1'b1;
              rw_ev   = 1'b1;
              state_d = sr[0] ? ST_SKIP : ST_DATA;
            end
          end else if (hi_ok && !sr[0]) begin
            act      = 1'b1;
            upd_ev   = 1'b1;
            rw_ev    = 1'b1;
            ten_ok_d = 1'b0;
            state_d  = ST_ADDR_LO;
          end else if (hi_ok && ten_ok_q) begin
            act   = 1'b1;
            rw_ev = 1'b1;
          end
        end
        ST_ADDR_LO: begin
          if (lo_ok) begin
            act      = 1'b1;
            upd_ev   = 1'b1;
            ten_ok_d = 1'b1;
            state_d  = ST_DATA;
          end else begin
            state_d = ST_SKIP;
          end
        end
        ST_DATA: act = 1'b1;
        default: ;
      endcase
      ack_d  = act && !buf_full && !ovf;
      irqp_d = act;
      updp_d = upd_ev;
    end else if (ack_end) begin
      ack_d  = 1'b0;
      irqp_d = 1'b0;
      updp_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ten_ok_q <= 1'b0;
      ack_q    <= 1'b0;
      irqp_q   <= 1'b0;
      updp_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      ten_ok_q <= ten_ok_d;
      ack_q    <= ack_d;
      irqp_q   <= irqp_d;
      updp_q   <= updp_d;
    end
  end

  assign xfer    = act && !buf_full && !ovf;
  assign set_ovf = act && buf_full;
  assign set_irq = ack_end && irqp_q && enable;
  assign set_upd = ack_end && updp_q && enable;
  assign rw_we   = rw_ev;
  assign sda_pd  = ack_q;
endmodule

// File: rtl/i2cr_rx.sv
module i2cr_rx
  import i2cr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_pd_o,
  output logic       sda_pd_o,
  output logic       irq_o,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o
);
  logic [RST_STAGES-1:0] rst_chain;
  logic                  rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain <= '0;
    else        rst_chain <= {rst_chain[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_chain[RST_STAGES-1];

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] sr;
  logic byte_end, ack_end;
  logic xfer, set_ovf, set_irq, set_upd, rw_we, ack_drv;

  logic en_q, en_d, ten_q, ten_d;
  logic [BYTE_W-1:0] adr_q, adr_d, buf_q, buf_d;
  logic full_q, full_d, ovf_q, ovf_d, irq_q, irq_d, upd_q, upd_d, rw_q, rw_d;
  logic wr_adr, wr_ctl, wr_st, rd_buf;

  i2cr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cr_shift u_shift (
    .clk(clk), .rst_n(rst_n_s), .clr(start_det | stop_det | ~en_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .sr(sr), .byte_end(byte_end), .ack_end(ack_end)
  );

  i2cr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .enable(en_q), .ten_bit(ten_q),
    .start_det(start_det), .stop_det(stop_det),
    .byte_end(byte_end), .ack_end(ack_end), .sr(sr), .adr(adr_q),
    .buf_full(full_q), .ovf(ovf_q),
    .xfer(xfer), .set_ovf(set_ovf), .set_irq(set_irq), .set_upd(set_upd),
    .rw_we(rw_we), .sda_pd(ack_drv)
  );

  assign wr_adr = reg_wr_i && (reg_addr_i == RA_SLADR);
  assign wr_ctl = reg_wr_i && (reg_addr_i == RA_CTRL);
  assign wr_st  = reg_wr_i && (reg_addr_i == RA_STAT);
  assign rd_buf = reg_rd_i && (reg_addr_i == RA_RXBUF);

  always_comb begin
    en_d   = wr_ctl ? reg_wdata_i[CTRL_EN]  : en_q;
    ten_d  = wr_ctl ? reg_wdata_i[CTRL_TEN] : ten_q;
    adr_d  = wr_adr ? reg_wdata_i : adr_q;
    buf_d  = xfer ? sr : buf_q;
    rw_d   = rw_we ? sr[0] : rw_q;
    full_d = full_q;
    if (rd_buf) full_d = 1'b0;
    if (xfer)   full_d = 1'b1;
    ovf_d = ovf_q;
    if (wr_st && reg_wdata_i[STAT_OVF]) ovf_d = 1'b0;
    if (set_ovf)                        ovf_d = 1'b1;
    irq_d = irq_q;
    if (wr_st && reg_wdata_i[STAT_IRQ]) irq_d = 1'b0;
    if (set_irq)                        irq_d = 1'b1;
    upd_d = upd_q;
    if (wr_adr)  upd_d = 1'b0;
    if (set_upd) upd_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      en_q   <= 1'b0;
      ten_q  <= 1'b0;
      adr_q  <= '0;
      buf_q  <= '0;
      rw_q   <= 1'b0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      ten_q  <= ten_d;
      adr_q  <= adr_d;
      buf_q  <= buf_d;
      rw_q   <= rw_d;
      full_q <= full_d;
      ovf_q  <= ovf_d;
      irq_q  <= irq_d;
      upd_q  <= upd_d;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_RXBUF: reg_rdata_o = buf_q;
      RA_SLADR: reg_rdata_o = adr_q;
      RA_CTRL: begin
        reg_rdata_o[CTRL_EN]  = en_q;
        reg_rdata_o[CTRL_TEN] = ten_q;
      end
      default: begin
        reg_rdata_o[STAT_FULL] = full_q;
        reg_rdata_o[STAT_OVF]  = ovf_q;
        reg_rdata_o[STAT_IRQ]  = irq_q;
        reg_rdata_o[STAT_UPD]  = upd_q;
        reg_rdata_o[STAT_RW]   = rw_q;
      end
    endcase
  end

  assign scl_pd_o = upd_q & en_q;
  assign sda_pd_o = ack_drv;
  assign irq_o    = irq_q;
endmodule

// File: rtl/i2cr_chk.sv
module i2cr_chk
  import i2cr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       byte_end,
  input logic       ack_end,
  input logic       xfer,
  input logic       full,
  input logic       ovf,
  input logic       irq,
  input logic       upd,
  input logic       sda_pd,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [1:0] reg_addr,
  input logic       wdata_ovf
);
  AST_XFER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> (!full && !ovf)); // R5
  AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pd) |-> $past(byte_end)); // R3
  AST_IRQ_NINTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ack_end)); // R4
  AST_UPD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd) |-> $past(reg_wr && reg_addr == RA_SLADR)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf) |-> $past(reg_wr && reg_addr == RA_STAT && wdata_ovf)); // R6
  AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(reg_rd && reg_addr == RA_RXBUF)); // R7
endmodule

bind i2cr_rx i2cr_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .byte_end(byte_end), .ack_end(ack_end),
  .xfer(xfer), .full(full_q), .ovf(ovf_q), .irq(irq_q), .upd(upd_q),
  .sda_pd(sda_pd_o), .reg_wr(reg_wr_i), .reg_rd(reg_rd_i),
  .reg_addr(reg_addr_i), .wdata_ovf(reg_wdata_i[1])
);

// File: tb/i2cr_rx_tb.sv
module i2cr_rx_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, scl_m, sda_m, wr, rd;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic scl_pd, sda_pd, irq;
  wire scl_line = scl_m & ~scl_pd;
  wire sda_line = sda_m & ~sda_pd;

  int n_chk = 0, n_fail = 0;
  bit m_full, m_ovf, m_irq, m_upd, m_rw, run_cmp;
  logic [7:0] m_buf;

  i2cr_rx u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pd_o(scl_pd), .sda_pd_o(sda_pd), .irq_o(irq),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (run_cmp) begin
    check(!(m_upd && !scl_pd), "R8 stretch", scl_pd, m_upd);
    check(!(m_irq && !irq), "R4 irq", irq, m_irq);
  end

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(posedge clk);
    if (a == 2'd1) m_upd = 0;
    if (a == 2'd3 && d[1]) m_ovf = 0;
    if (a == 2'd3 && d[2]) m_irq = 0;
    @(negedge clk); wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1; addr = a;
    #1 d = rdata;
    @(posedge clk);
    if (a == 2'd0) m_full = 0;
    @(negedge clk); rd = 0;
  endtask

  task automatic chk_status(input string req);
    logic [7:0] d;
    reg_read(2'd3, d);
    check(d[4:0] == {m_rw, m_upd, m_irq, m_ovf, m_full}, req, d[4:0],
          {m_rw, m_upd, m_irq, m_ovf, m_full});
  endtask

  task automatic chk_buf(input string req);
    logic [7:0] d;
    reg_read(2'd0, d);
    check(d == m_buf, req, d, m_buf);
  endtask

  task automatic wait_scl;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1; scl_m = 1; wait_scl; repeat (Q) @(negedge clk);
    sda_m = 0; repeat (Q) @(negedge clk);
    scl_m = 0; repeat (Q) @(negedge clk);
  endtask

  task automatic bus_rstart;
    sda_m = 1; repeat (Q) @(negedge clk);
    scl_m = 1; wait_scl; repeat (Q) @(negedge clk);
    sda_m = 0; repeat (Q) @(negedge clk);
    scl_m = 0; repeat (Q) @(negedge clk);
  endtask

  task automatic bus_stop;
    sda_m = 0; repeat (Q) @(negedge clk);
    scl_m = 1; wait_scl; repeat (Q) @(negedge clk);
    sda_m = 1; repeat (Q) @(negedge clk);
  endtask

  // coinc: raise a buffer read strobe in the clock the byte is judged
  task automatic send_byte(input logic [7:0] b, input bit coinc,
                           output bit ack, output logic [7:0] cap);
    cap = '0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; repeat (Q) @(negedge clk);
      scl_m = 1; wait_scl; repeat (Q) @(negedge clk);
      scl_m = 0;
      if (i == 0 && coinc) begin
        repeat (2) @(negedge clk);
        rd = 1; addr = 2'd0;
        #1 cap = rdata;
        @(negedge clk); rd = 0;
        repeat (Q - 3) @(negedge clk);
      end else begin
        repeat (Q) @(negedge clk);
      end
    end
    sda_m = 1; repeat (Q) @(negedge clk);
    scl_m = 1; wait_scl; repeat (Q / 2) @(negedge clk);
    ack = !sda_line;
    repeat (Q / 2) @(negedge clk);
    scl_m = 0; repeat (Q) @(negedge clk);
  endtask

  task automatic model_byte(input logic [7:0] b, input bit act, input bit updev,
                            output bit exp_ack);
    exp_ack = act && !m_full && !m_ovf;
    if (act) begin
      if (exp_ack) begin m_buf = b; m_full = 1; end
      else if (m_full) m_ovf = 1;
      m_irq = 1;
      if (updev) m_upd = 1;
    end
  endtask

  task automatic xfer_byte(input logic [7:0] b, input bit act, input bit updev,
                           input string req);
    bit ack, e;
    logic [7:0] cap;
    send_byte(b, 1'b0, ack, cap);
    model_byte(b, act, updev, e);
    check(ack == e, req, ack, e);
  endtask

  task automatic finish_up;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_up;
  end

  initial begin
    logic [7:0] d, cap;
    bit ack, e;
    rst_n = 0; scl_m = 1; sda_m = 1; wr = 0; rd = 0; addr = 0; wdata = 0;
    m_full = 0; m_ovf = 0; m_irq = 0; m_upd = 0; m_rw = 0; m_buf = 0; run_cmp = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check({scl_pd, sda_pd, irq} == 3'b000, "R1 outputs", {scl_pd, sda_pd, irq}, 0);
    chk_status("R1 status");
    reg_read(2'd2, d); check(d == 0, "R1 ctrl", d, 0);
    reg_read(2'd1, d); check(d == 0, "R1 addr", d, 0);
    run_cmp = 1;

    // R2 disabled block ignores the bus
    reg_write(2'd1, 8'hA4);
    bus_start; xfer_byte(8'hA4, 0, 0, "R2 disabled"); bus_stop;
    chk_status("R2 status disabled");
    reg_write(2'd2, 8'h01);
    xfer_byte(8'hA4, 0, 0, "R2 no start");
    bus_stop;
    chk_status("R2 status no start");

    // R3 7-bit match, R7 read clears full
    bus_start; xfer_byte(8'hA4, 1, 0, "R3 match ack"); m_rw = 0;
    bus_stop;
    chk_status("R3 status"); chk_buf("R3 R7 buffer"); chk_status("R7 full cleared");
    // R4 clear irq
    reg_write(2'd3, 8'h04);
    check(irq == 0, "R4 irq cleared", irq, 0);
    bus_start; xfer_byte(8'hA6, 0, 0, "R3 mismatch"); xfer_byte(8'hA4, 0, 0, "R3 skip data");
    bus_stop;
    chk_status("R3 mismatch status");

    // R5 R6 action table
    bus_start; xfer_byte(8'hA4, 1, 0, "R5 addr ack");
    xfer_byte(8'h3C, 1, 0, "R5 R6 full nak");
    xfer_byte(8'h55, 1, 0, "R5 full ovf nak");
    chk_status("R6 ovf set"); chk_buf("R5 buffer kept");
    xfer_byte(8'h66, 1, 0, "R5 ovf only nak");
    chk_status("R6 ovf sticky");
    reg_write(2'd3, 8'h06);
    xfer_byte(8'h77, 1, 0, "R5 ack after clear");
    bus_stop;
    chk_buf("R5 buffer new");

    // R11 stop returns idle
    xfer_byte(8'hA4, 0, 0, "R11 after stop");
    chk_status("R11 status");

    // R12 read strobe coincides with judgement
    reg_write(2'd3, 8'h06);
    bus_start; xfer_byte(8'hA4, 1, 0, "R12 addr");
    send_byte(8'h99, 1'b1, ack, cap);
    check(cap == m_buf, "R12 read data", cap, m_buf);
    model_byte(8'h99, 1, 0, e); m_full = 0;
    check(ack == e, "R12 nak", ack, e);
    bus_stop;
    chk_status("R12 status");
    reg_write(2'd3, 8'h06);

    // R8 R9 R10 ten-bit address 0x2B5
    reg_write(2'd2, 8'h03); reg_write(2'd1, 8'hF4);
    bus_start; xfer_byte(8'hF4, 1, 1, "R8 high ack"); m_rw = 0;
    repeat (20) @(negedge clk);
    check(scl_pd == 1, "R8 hold", scl_pd, 1);
    chk_status("R8 status"); chk_buf("R8 buffer");
    reg_write(2'd3, 8'h04); reg_write(2'd1, 8'hB5);
    check(scl_pd == 0, "R8 release", scl_pd, 0);
    xfer_byte(8'hB5, 1, 1, "R9 low ack");
    chk_status("R9 status"); chk_buf("R9 buffer");
    reg_write(2'd3, 8'h04); reg_write(2'd1, 8'hF4);
    xfer_byte(8'h5A, 1, 0, "R9 data ack"); chk_buf("R9 data");
    bus_rstart; xfer_byte(8'hF5, 1, 0, "R10 read ack"); m_rw = 1;
    bus_stop;
    chk_status("R10 status"); chk_buf("R10 buffer");
    reg_write(2'd3, 8'h04);
    bus_start; xfer_byte(8'hF5, 0, 0, "R10 after stop"); bus_stop;
    bus_start; xfer_byte(8'hF2, 0, 0, "R8 high mismatch"); bus_stop;
    bus_start; xfer_byte(8'hF4, 1, 1, "R9 high again"); m_rw = 0;
    chk_buf("R9 buf"); reg_write(2'd3, 8'h04); reg_write(2'd1, 8'hB5);
    xfer_byte(8'hB6, 0, 0, "R9 low mismatch");
    bus_stop;
    chk_status("R9 mismatch status");

    run_cmp = 0;
    finish_up;
  end
endmodule